// File: doc/BRIEF.md
# Transmit Frame Check Sequence Inserter with Underflow Poisoning

This block sits at the transmit end of a gigabit MAC. It takes frame bytes from a byte-wide stream marked with start, end and valid flags, together with an underflow flag from the buffer that feeds it. Each byte goes out one cycle later on a GMII-style byte bus qualified by a transmit-enable. While the bytes pass through, the block runs the Ethernet CRC-32 over them. After the last byte it appends the four frame-check bytes.

If the feeding buffer runs dry in the middle of a frame, the block keeps transmit-enable high and sends filler bytes. The frame still runs to its end. The block then appends the bitwise complement of the correct check value, so every receiver discards the frame. No separate transmit-error line exists: the bad check value is the only error signal. Preamble, start delimiter, padding and the physical coding layer are handled elsewhere.

Top module: `eth_tx_fcs_inserter`

## Requirements
- R1: The check value is the reflected CRC-32 (polynomial 0xEDB88320, register preset to 0xFFFFFFFF, each byte processed least significant bit first). The appended check is the complement of the final register, sent least significant byte first right after the last frame byte. Running the same CRC over a whole clean frame, check bytes included, leaves the register at 0xDEBB20E3.
- R2: A byte accepted in cycle t appears on `tx_data` in cycle t+1 with `tx_en` high. `tx_en` stays high without a break from the first frame byte through the fourth check byte.
- R3: After the fourth check byte, `tx_en` stays low for exactly GAP_CYCLES cycles (default 1) before a new frame can start. A start offered during the check bytes or during that gap is discarded.
- R4: Inside a frame, a cycle with `in_underflow` high or `in_valid` low is a missing byte. The block sends a filler byte in that cycle, keeps `tx_en` high and continues the frame.
- R5: With FILL_ZERO=0 the filler repeats the byte last sent. With FILL_ZERO=1 the filler is 0x00.
- R6: In a frame that had any missing byte, the four check bytes are the bitwise inverse of the correct check value over the bytes actually sent, filler included. The frame is sent to completion and its residue differs from 0xDEBB20E3.
- R7: The poisoned state lasts only until the next accepted start. A clean frame that follows a poisoned one carries a correct check value.
- R8: If `in_underflow` is high in the same cycle as the end marker, that byte is replaced by filler, the frame still closes there, and it is poisoned.
- R9: A frame whose start and end markers fall on the same byte produces five bytes on the wire: the byte followed by four check bytes.
- R10: After reset, `tx_en` is low and `tx_data` is 0x00.
- R11: Whenever `tx_en` is low, `tx_data` is 0x00.
- R12: If `in_underflow` is high on the start cycle, the byte presented there is still sent as data, and the frame is poisoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte on `in_data` is present |
| in_sop | input | 1 | First byte of a frame |
| in_eop | input | 1 | Last byte of a frame |
| in_data | input | 8 | Frame byte |
| in_underflow | input | 1 | Feeding buffer has run dry this cycle |
| tx_data | output | 8 | Byte to the physical layer |
| tx_en | output | 1 | `tx_data` carries frame or check bytes |

## Verification
Two events can fall in the same cycle: the closing byte and a buffer underflow. The bench drives `in_underflow` high together with `in_eop`. It then expects three things at once: filler in place of the final byte, the frame closing at that point, and inverted check bytes. It judges the result by the received byte sequence and by a residue that must differ from 0xDEBB20E3. A second overlap happens when a new start is offered during the appended check bytes. The bench judges that case by requiring that the discarded starts leave no trace on the wire and that the following gap is one cycle long.

// File: rtl/eth_fcs_pkg.sv
package eth_fcs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DATA = 2'd1,
      ST_FCS  = 2'd2,
      ST_GAP  = 2'd3
   } tx_state_t;

   localparam int unsigned FCS_BYTES = 4;

   // one reflected LFSR step for a single input bit
   function automatic logic [31:0] crc_bit_step(input logic [31:0] c,
                                                input logic        b,
                                                input logic [31:0] poly);
      crc_bit_step = (c[0] ^ b) ? ((c >> 1) ^ poly) : (c >> 1);
   endfunction

endpackage

// File: rtl/fcs_crc_byte.sv
module fcs_crc_byte
   import eth_fcs_pkg::*;
#(
   parameter logic [31:0] POLY = 32'hEDB88320,
   parameter int unsigned IMPL = 1        // 0: bit-serial chain, 1: nibble lookup
)(
   input  logic [31:0] crc_i,
   input  logic [7:0]  byte_i,
   output logic [31:0] crc_o
);

   if (IMPL > 1) begin : g_bad_impl
      $error("fcs_crc_byte: IMPL must be 0 or 1");
   end

   if (IMPL == 0) begin : g_bitwise
      always_comb begin
         logic [31:0] c;
         c = crc_i;
         for (int i = 0; i < 8; i++) begin
            c = crc_bit_step(c, byte_i[i], POLY);
         end
         crc_o = c;
      end
   end else begin : g_nibble
      // value reached by shifting a lone nibble through four steps
      function automatic logic [31:0] nib_entry(input logic [3:0] n);
         logic [31:0] c;
         c = {28'd0, n};
         for (int k = 0; k < 4; k++) begin
            c = crc_bit_step(c, 1'b0, POLY);
         end
         return c;
      endfunction

      always_comb begin
         logic [31:0] c;
         c = crc_i;
         c = (c >> 4) ^ nib_entry(c[3:0] ^ byte_i[3:0]);
         c = (c >> 4) ^ nib_entry(c[3:0] ^ byte_i[7:4]);
         crc_o = c;
      end
   end

endmodule

// File: rtl/fcs_poison_flag.sv
module fcs_poison_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic start,      // a new frame is accepted this cycle
   input  logic start_err,  // underflow seen on the start cycle
   input  logic hit,        // missing byte inside a frame
   output logic poison
);

   logic poison_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         poison_q <= 1'b0;
      else if (start)
         poison_q <= start_err;
      else if (hit)
         poison_q <= 1'b1;
   end

   assign poison = poison_q;

   // R7: once set, the flag holds until a new start
   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (poison_q && !start) |=> poison_q);

   // R4: a missing byte always marks the frame
   p_hit_marks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !start) |=> poison_q);

endmodule

// File: rtl/eth_tx_fcs_inserter.sv
module eth_tx_fcs_inserter
   import eth_fcs_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter logic [31:0] POLY       = 32'hEDB88320,
   parameter logic [31:0] CRC_INIT   = 32'hFFFFFFFF,
   parameter int unsigned GAP_CYCLES = 1,
   parameter int unsigned CRC_IMPL   = 1,
   parameter bit          FILL_ZERO  = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sop,
   input  logic              in_eop,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_underflow,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_en
);

   localparam int unsigned GAP_W = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES);
   localparam int unsigned IDX_W = $clog2(FCS_BYTES);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FCS_BYTES - 1);
   localparam logic [GAP_W-1:0] GAP_END  = GAP_W'(GAP_CYCLES - 1);

   if (DATA_W != 8) begin : g_bad_width
      $error("eth_tx_fcs_inserter: DATA_W must be 8");
   end
   if (GAP_CYCLES < 1) begin : g_bad_gap
      $error("eth_tx_fcs_inserter: GAP_CYCLES must be at least 1");
   end

   tx_state_t         state_q;
   logic [IDX_W-1:0]  fcs_idx_q;
   logic [GAP_W-1:0]  gap_cnt_q;
   logic [31:0]       crc_q;
   logic [7:0]        last_q;
   logic [7:0]        data_q;
   logic              en_q;

   logic              take_sop;
   logic              in_frame;
   logic              good_byte;
   logic              closing;
   logic              miss;
   logic [7:0]        filler;
   logic [7:0]        send_byte;
   logic [31:0]       crc_base;
   logic [31:0]       crc_nxt;
   logic [31:0]       fcs_word;
   logic              poison;

   assign take_sop  = (state_q == ST_IDLE) && in_valid && in_sop;
   assign in_frame  = (state_q == ST_DATA);
   assign good_byte = in_valid && !in_underflow;
   assign miss      = in_frame && !good_byte;
   assign closing   = (take_sop || in_frame) && in_valid && in_eop;

   if (FILL_ZERO) begin : g_fill_zero
      assign filler = 8'h00;
   end else begin : g_fill_repeat
      assign filler = last_q;
   end

   assign send_byte = (take_sop || good_byte) ? in_data : filler;
   assign crc_base  = take_sop ? CRC_INIT : crc_q;

   fcs_crc_byte #(
      .POLY (POLY),
      .IMPL (CRC_IMPL)
   ) u_crc (
      .crc_i  (crc_base),
      .byte_i (send_byte),
      .crc_o  (crc_nxt)
   );

   fcs_poison_flag u_poison (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (take_sop),
      .start_err (take_sop && in_underflow),
      .hit       (miss),
      .poison    (poison)
   );

   // clean: complement of register; poisoned: inverse of that
   assign fcs_word = poison ? crc_q : ~crc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         fcs_idx_q <= '0;
         gap_cnt_q <= '0;
         crc_q     <= CRC_INIT;
         last_q    <= 8'h00;
         data_q    <= 8'h00;
         en_q      <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               en_q   <= take_sop;
               data_q <= take_sop ? send_byte : 8'h00;
               if (take_sop) begin
                  crc_q     <= crc_nxt;
                  last_q    <= send_byte;
                  fcs_idx_q <= '0;
                  state_q   <= closing ? ST_FCS : ST_DATA;
               end
            end
            ST_DATA: begin
               en_q   <= 1'b1;
               data_q <= send_byte;
               crc_q  <= crc_nxt;
               last_q <= send_byte;
               if (closing) begin
                  fcs_idx_q <= '0;
                  state_q   <= ST_FCS;
               end
            end
            ST_FCS: begin
               en_q      <= 1'b1;
               data_q    <= fcs_word[8*fcs_idx_q +: 8];
               fcs_idx_q <= fcs_idx_q + 1'b1;
               if (fcs_idx_q == LAST_IDX) begin
                  gap_cnt_q <= '0;
                  state_q   <= ST_GAP;
               end
            end
            ST_GAP: begin
               en_q      <= 1'b0;
               data_q    <= 8'h00;
               gap_cnt_q <= gap_cnt_q + 1'b1;
               if (gap_cnt_q == GAP_END)
                  state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign tx_data = data_q;
   assign tx_en   = en_q;

   // R2: inside a frame the enable never breaks
   p_stream_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DATA) |=> tx_en);

   // R1: the closing byte is followed by the first check byte
   p_fcs_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      closing |=> (state_q == ST_FCS) && (fcs_idx_q == '0));

   // R3: enable drops after the fourth check byte
   p_gap_after_fcs_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FCS && fcs_idx_q == LAST_IDX) |-> ##2 !tx_en);

   // R3: no start is taken while check bytes or gap are in progress
   p_no_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FCS || state_q == ST_GAP) |=> (state_q != ST_DATA));

   // R11: idle bus is quiet
   p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && !take_sop) |=> (!tx_en && tx_data == 8'h00));

endmodule

// File: tb/eth_tx_fcs_inserter_test.sv
module eth_tx_fcs_inserter_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_underflow = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic [7:0] tx_data, tx_data_z;
   logic       tx_en, tx_en_z;

   always #5 clk = ~clk;

   eth_tx_fcs_inserter uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
      .in_eop(in_eop), .in_data(in_data), .in_underflow(in_underflow),
      .tx_data(tx_data), .tx_en(tx_en));

   eth_tx_fcs_inserter #(.CRC_IMPL(0), .FILL_ZERO(1'b1)) uut_z (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
      .in_eop(in_eop), .in_data(in_data), .in_underflow(in_underflow),
      .tx_data(tx_data_z), .tx_en(tx_en_z));

   int checks = 0;
   int fails  = 0;

   // received and expected byte streams
   logic [7:0] rx_q[$], rxz_q[$], exp_q[$], expz_q[$];
   int         low_run = 0, last_gap = -1, quiet_bad = 0;

   // reference model state
   bit         m_in_frame = 0, m_poison = 0, m_last_poison = 0;
   int         m_busy = 0;
   logic [31:0] m_crc_l, m_crc_z;
   logic [7:0]  m_last = 8'h00;

   function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
      logic [31:0] r;
      r = c;
      for (int i = 0; i < 8; i++)
         r = (r[0] ^ b[i]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // monitor, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (tx_en) begin
            if (low_run > 0) last_gap = low_run;
            low_run = 0;
            rx_q.push_back(tx_data);
         end else begin
            low_run++;
            if (tx_data != 8'h00) quiet_bad++;
         end
         if (tx_en_z) rxz_q.push_back(tx_data_z);
      end
   end

   task automatic model_close();
      for (int k = 0; k < 4; k++) begin
         exp_q.push_back(m_poison ? m_crc_l[8*k +: 8] : ~m_crc_l[8*k +: 8]);
         expz_q.push_back(m_poison ? m_crc_z[8*k +: 8] : ~m_crc_z[8*k +: 8]);
      end
      m_last_poison = m_poison;
      m_in_frame = 0;
      m_busy = 5;
   endtask

   // drive one cycle and advance the model
   task automatic send(input bit v, input bit s, input bit e, input logic [7:0] d, input bit u);
      logic [7:0] bl, bz;
      in_valid = v; in_sop = s; in_eop = e; in_data = d; in_underflow = u;
      if (!m_in_frame) begin
         if (m_busy > 0) m_busy--;
         else if (v && s) begin
            m_poison = u;
            m_crc_l = ref_crc(32'hFFFFFFFF, d);
            m_crc_z = m_crc_l;
            exp_q.push_back(d); expz_q.push_back(d);
            m_last = d; m_in_frame = 1;
            if (e) model_close();
         end
      end else begin
         bl = (v && !u) ? d : m_last;
         bz = (v && !u) ? d : 8'h00;
         if (!(v && !u)) m_poison = 1;
         exp_q.push_back(bl); expz_q.push_back(bz);
         m_crc_l = ref_crc(m_crc_l, bl);
         m_crc_z = ref_crc(m_crc_z, bz);
         m_last = bl;
         if (v && e) model_close();
      end
      @(posedge clk); #1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) send(0, 0, 0, 8'h00, 0);
   endtask

   task automatic compare(input string req);
      bit ok;
      ok = (rx_q.size() == exp_q.size());
      if (ok) for (int i = 0; i < rx_q.size(); i++) if (rx_q[i] !== exp_q[i]) ok = 0;
      check(ok, req, "byte stream (repeat fill)", rx_q.size(), exp_q.size());
      ok = (rxz_q.size() == expz_q.size());
      if (ok) for (int i = 0; i < rxz_q.size(); i++) if (rxz_q[i] !== expz_q[i]) ok = 0;
      check(ok, req, "byte stream (zero fill)", rxz_q.size(), expz_q.size());
   endtask

   task automatic residue(input string req);
      logic [31:0] c;
      c = 32'hFFFFFFFF;
      foreach (rx_q[i]) c = ref_crc(c, rx_q[i]);
      if (m_last_poison)
         check(c != 32'hDEBB20E3, req, "poisoned residue", c, ~32'hDEBB20E3);
      else
         check(c == 32'hDEBB20E3, req, "clean residue", c, 32'hDEBB20E3);
   endtask

   task automatic flush();
      rx_q.delete(); rxz_q.delete(); exp_q.delete(); expz_q.delete();
   endtask

   // {len, seed, miss_at (255 none), miss_cycles, kind: 0 flag, 1 valid low, 2 at end}
   localparam int NVEC = 8;
   localparam logic [31:0] VECS [NVEC] = '{
      {8'd1,  8'h3C, 8'd255, 4'd0, 4'd0},   // R9 single byte
      {8'd4,  8'h11, 8'd255, 4'd0, 4'd0},   // R1 short clean
      {8'd60, 8'hA7, 8'd255, 4'd0, 4'd0},   // R1 long clean
      {8'd20, 8'h05, 8'd5,   4'd2, 4'd0},   // R4 R6 flag underflow
      {8'd20, 8'h92, 8'd10,  4'd3, 4'd1},   // R4 R5 valid gap
      {8'd16, 8'h48, 8'd15,  4'd1, 4'd2},   // R8 underflow with end
      {8'd8,  8'hE1, 8'd255, 4'd0, 4'd0},   // R7 clean after poisoned
      {8'd64, 8'h6D, 8'd63,  4'd1, 4'd0}    // R6 late underflow
   };
   localparam string VREQ [NVEC] = '{"R9", "R1", "R1", "R6", "R4", "R8", "R7", "R6"};

   initial begin
      fork
         begin
            repeat (50000) @(posedge clk);
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
         end
      join_none

      repeat (3) @(posedge clk); #1;
      // R10: reset state
      check(tx_en == 1'b0 && tx_data == 8'h00, "R10", "reset outputs", {tx_en, tx_data}, 0);
      rst_n = 1'b1;
      @(posedge clk); #1;

      for (int v = 0; v < NVEC; v++) begin
         int len, at, n, kind;
         logic [7:0] seed;
         len = VECS[v][31:24]; seed = VECS[v][23:16];
         at = VECS[v][15:8]; n = VECS[v][7:4]; kind = VECS[v][3:0];
         for (int i = 0; i < len; i++) begin
            logic [7:0] b;
            b = seed + 8'(i * 37);
            if (i == at && kind != 2)
               for (int k = 0; k < n; k++) send(kind == 1 ? 0 : 1, 0, 0, 8'hEE, kind == 0);
            send(1, i == 0, i == len - 1, b, kind == 2 && i == len - 1);
         end
         idle(8);
         compare(VREQ[v]);
         residue(VREQ[v]);
         flush();
      end

      // R2: one-cycle latency and continuous enable
      send(1, 1, 0, 8'hA5, 0);
      check(tx_en && tx_data == 8'hA5, "R2", "first byte latency", {tx_en, tx_data}, {1'b1, 8'hA5});
      send(1, 0, 0, 8'h5A, 0);
      send(1, 0, 1, 8'hC3, 0);
      idle(8);
      compare("R2");
      flush();

      // R3: starts offered during check bytes and gap are dropped
      for (int i = 0; i < 6; i++) send(1, i == 0, i == 5, 8'(8'h20 + i), 0);
      for (int i = 0; i < 5; i++) send(1, 1, 1, 8'hF0, 0);
      for (int i = 0; i < 3; i++) send(1, i == 0, i == 2, 8'(8'h70 + i), 0);
      idle(8);
      compare("R3");
      check(last_gap == 1, "R3", "gap length", last_gap, 1);
      flush();

      // R12: underflow on the start cycle keeps the byte, poisons frame
      send(1, 1, 0, 8'h99, 1);
      send(1, 0, 1, 8'h77, 0);
      idle(8);
      compare("R12");
      residue("R12");
      flush();

      // R11: bus quiet whenever enable is low
      check(quiet_bad == 0, "R11", "data while idle", quiet_bad, 0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule